// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the time-base stage of a two-channel PWM generator. The input clock first passes through a prescaler with two cascaded stages. One stage divides by a power of two. The other divides by one or by an even number. Each prescaled tick then moves a 16-bit counter by one step, against an active period value. The counter can count up, count down or count up-down, or it can freeze.

Software sets the block up through a 16-bit write port with an address and a combinational read port. A control word at offset 0x00 holds the prescaler codes, the period-load policy and the counting mode. The period value sits at offset 0x0A. A period write can go to a shadow copy, which is promoted to the active period when the counter passes through zero. It can also go straight to the active period. The downstream action stage receives the live count, the counting direction, and one-clock strobes that mark a zero match and a period match.

Top module: `tbase_timer`

## Requirements
- R1: After reset the control word and the period are 0, the count is 0, the direction reads as up (dir_up=1), and every clock is a tick (ratio 1).
- R2: The control word lives at offset 0x00 and keeps only bits 12:7, 3 and 1:0. Its other bits read back 0. A read at 0x0A returns the active period. Writes to any other offset change nothing, and reads there return 0.
- R3: The clock ratio is (2^c)·(h==0 ? 1 : 2h), with c in control bits 12:10 and h in control bits 9:7. The count moves exactly once per ratio clocks.
- R4: Mode 00 (control bits 1:0) counts up. On a tick with count >= period, the count goes to 0.
- R5: Mode 01 counts down. On a tick with count 0, the count reloads the active period.
- R6: Mode 10 counts up-down. On a tick while counting up with count >= period, dir_up drops and the count steps down. On a tick while counting down with count 0, dir_up rises and the count steps up. A period of 0 holds the count at 0.
- R7: Mode 11 freezes the count and the direction, and no strobe is raised.
- R8: zero_evt is high for one clock on each tick where the count is 0. prd_evt is high on each tick where the count equals the active period. Neither is raised in mode 11.
- R9: With control bit 3 = 0, a period write fills only the shadow copy. The active period takes the shadow value on the edge after a zero_evt clock.
- R10: With control bit 3 = 1, a period write updates the active period at once. This write wins over a shadow promotion in the same clock.
- R11: The full period value 0xFFFF is usable. In down mode the count reloads from 0 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data at addr (combinational) |
| count | output | 16 | Current count |
| dir_up | output | 1 | 1 while counting up |
| zero_evt | output | 1 | Zero-match strobe |
| prd_evt | output | 1 | Period-match strobe |

## Verification
A cycle-accurate scoreboard follows the count, direction and both strobes through every mode. It covers a change of prescaler ratio in the middle of a count, where a design that compares for equality would stall for a full wrap of its prescaler. A period write made while frozen in shadow mode must read back the old value until the next zero. A design that loads immediately would show the new value too early. The bench also checks the turn points of the up-down mode and the reload from 0 to 0xFFFF in down mode. An off-by-one turn would show up as a repeated count value or as a missing strobe.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int RATIO_W = 11;      // largest ratio 128*14 = 1792
  localparam int CTL_W   = 16;

  // control-word field positions
  localparam int POW_LSB  = 10;
  localparam int EVEN_LSB = 7;
  localparam int LDM_BIT  = 3;
  localparam logic [CTL_W-1:0] CTL_KEEP = 16'h1F8B;

  typedef enum logic [1:0] {
    MODE_UP   = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_HOLD = 2'b11
  } cnt_mode_e;

  // ratio of the two cascaded stages
  function automatic logic [RATIO_W-1:0] scale_ratio(input logic [2:0] pow_code,
                                                     input logic [2:0] even_code);
    logic [RATIO_W-1:0] stage2;
    stage2 = (even_code == 3'd0) ? RATIO_W'(1) : RATIO_W'({even_code, 1'b0});
    return stage2 << pow_code;
  endfunction

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale
  import tbase_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         pow_code,
  input  logic [2:0]         even_code,
  output logic               tick_o
);
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] pcnt_q;

  assign ratio  = scale_ratio(pow_code, even_code);
  // >= so that a lowered ratio never waits for a wrap
  assign tick_o = (pcnt_q >= ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt_q <= '0;
    else if (tick_o) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ratio > 1) |=> (!tick_o || ratio != $past(ratio))); // R3

endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int CTL_ADDR = 0,
  parameter int PRD_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              zero_evt,
  output logic [DATA_W-1:0] rdata,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] prd_o
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] PRD_A = ADDR_W'(PRD_ADDR);

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] shd_q, act_q;
  logic wr_ctl, wr_prd, direct_ld;

  assign wr_ctl    = wr_en && (addr == CTL_A);
  assign wr_prd    = wr_en && (addr == PRD_A);
  assign direct_ld = ctl_q[LDM_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata[CTL_W-1:0] & CTL_KEEP;
      if (zero_evt) act_q <= shd_q;                 // promotion at zero
      if (wr_prd) begin
        shd_q <= wdata;
        if (direct_ld) act_q <= wdata;              // later NBA wins
      end
    end
  end

  always_comb begin
    if (addr == CTL_A)      rdata = DATA_W'(ctl_q);
    else if (addr == PRD_A) rdata = act_q;
    else                    rdata = '0;
  end

  assign ctl_o = ctl_q;
  assign prd_o = act_q;

  AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_prd && !zero_evt) |=> $stable(act_q)); // R9
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_prd && direct_ld) |=> (act_q == $past(wdata))); // R10
  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> ((ctl_q & ~CTL_KEEP) == '0)); // R2

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cnt_mode_e         mode,
  input  logic [DATA_W-1:0] prd,
  output logic [DATA_W-1:0] cnt_o,
  output logic              dir_up_o,
  output logic              zero_evt_o,
  output logic              prd_evt_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              up_q, up_d;
  logic              live;

  assign live = tick && (mode != MODE_HOLD);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick) begin
      case (mode)
        MODE_UP:   cnt_d = (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
        MODE_DOWN: cnt_d = (cnt_q == '0) ? prd : cnt_q - 1'b1;
        MODE_UPDN: begin
          if (up_q) begin
            if (cnt_q >= prd) begin
              up_d  = 1'b0;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              up_d  = 1'b1;
              cnt_d = (prd == '0) ? '0 : DATA_W'(1);
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_up_o   = up_q;
  assign zero_evt_o = live && (cnt_q == '0);
  assign prd_evt_o  = live && (cnt_q == prd);

  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> ($stable(cnt_o) && $stable(dir_up_o))); // R7
  AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_o)); // R3
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UP && cnt_o >= prd) |=> (cnt_o == '0)); // R4
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_DOWN && cnt_o == '0) |=> (cnt_o == $past(prd))); // R5
  AST_TURN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_UPDN && dir_up_o && cnt_o >= prd) |=> !dir_up_o); // R6
  AST_NO_HOLD_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |-> !(zero_evt_o || prd_evt_o)); // R8

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int CTL_ADDR = 0,
  parameter int PRD_ADDR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] count,
  output logic              dir_up,
  output logic              zero_evt,
  output logic              prd_evt
);
  logic [CTL_W-1:0]  ctl;
  logic [DATA_W-1:0] act_prd;
  logic              tick;
  cnt_mode_e         mode;

  assign mode = cnt_mode_e'(ctl[1:0]);

  tbase_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .PRD_ADDR(PRD_ADDR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .zero_evt(zero_evt), .rdata(rdata), .ctl_o(ctl), .prd_o(act_prd)
  );

  tbase_prescale presc_i (
    .clk(clk), .rst_n(rst_n),
    .pow_code(ctl[POW_LSB+2:POW_LSB]), .even_code(ctl[EVEN_LSB+2:EVEN_LSB]),
    .tick_o(tick)
  );

  tbase_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .prd(act_prd),
    .cnt_o(count), .dir_up_o(dir_up), .zero_evt_o(zero_evt), .prd_evt_o(prd_evt)
  );

endmodule

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count;
  logic        dir_up, zero_evt, prd_evt;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  tbase_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count(count), .dir_up(dir_up),
    .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { int cnt; bit dir; bit z; bit p; string tag; } exp_t;
  exp_t sb_q[$];

  int m_pcnt, m_cnt, m_c, m_h, m_mode, m_prd, m_shd;
  bit m_dir, m_direct;

  function automatic int ratio_of(int c, int h);
    return (h == 0) ? (1 << c) : ((h * 2) << c);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pcnt = 0; m_cnt = 0; m_c = 0; m_h = 0; m_mode = 0;
      m_prd = 0; m_shd = 0; m_dir = 1; m_direct = 0;
    end else begin
      bit tk, zz, tk2;
      int ncnt, nprd, nshd;
      bit ndir;
      exp_t e;
      tk   = (m_pcnt + 1 >= ratio_of(m_c, m_h));
      zz   = tk && m_mode != 3 && m_cnt == 0;
      ncnt = m_cnt; ndir = m_dir;
      if (tk) begin
        if (m_mode == 0) ncnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
        else if (m_mode == 1) ncnt = (m_cnt == 0) ? m_prd : m_cnt - 1;
        else if (m_mode == 2) begin
          if (m_dir && m_cnt >= m_prd) begin ndir = 0; ncnt = (m_cnt > 0) ? m_cnt - 1 : 0; end
          else if (m_dir) ncnt = m_cnt + 1;
          else if (m_cnt == 0) begin ndir = 1; ncnt = (m_prd > 0) ? 1 : 0; end
          else ncnt = m_cnt - 1;
        end
      end
      nprd = zz ? m_shd : m_prd;
      nshd = m_shd;
      if (wr_en && addr == 5'd10) begin
        nshd = int'(wdata);
        if (m_direct) nprd = int'(wdata);
      end
      if (wr_en && addr == 5'd0) begin
        m_c = int'(wdata[12:10]); m_h = int'(wdata[9:7]);
        m_direct = wdata[3]; m_mode = int'(wdata[1:0]);
      end
      m_pcnt = tk ? 0 : m_pcnt + 1;
      m_cnt = ncnt; m_dir = ndir; m_prd = nprd; m_shd = nshd;
      tk2 = (m_pcnt + 1 >= ratio_of(m_c, m_h));
      e.cnt = m_cnt; e.dir = m_dir;
      e.z = tk2 && m_mode != 3 && m_cnt == 0;
      e.p = tk2 && m_mode != 3 && m_cnt == m_prd;
      e.tag = cur_tag;
      sb_q.push_back(e);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(int'(count) == e.cnt, {e.tag, " count"}, int'(count), e.cnt);
      chk(dir_up == e.dir, {e.tag, " dir_up"}, dir_up, e.dir);
      chk(zero_evt == e.z, {e.tag, " zero_evt"}, zero_evt, e.z);
      chk(prd_evt == e.p, {e.tag, " prd_evt"}, prd_evt, e.p);
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int zc, pc, n, prev;
    bit hit;
    run(3);
    // R1 reset state
    chk(count == 16'd0, "R1 count", int'(count), 0);
    chk(dir_up == 1'b1, "R1 dir_up", dir_up, 1);
    chk(zero_evt && prd_evt, "R8 reset strobes", {zero_evt, prd_evt}, 3);
    rd(5'd0, v);  chk(v == 16'h0, "R1 ctl", v, 0);
    rd(5'd10, v); chk(v == 16'h0, "R1 prd", v, 0);
    @(negedge clk) rst_n = 1'b1;

    // R10 immediate load, up mode
    cur_tag = "R10";
    wr(5'd0, 16'h0008);
    wr(5'd10, 16'd5);
    rd(5'd10, v); chk(v == 16'd5, "R10 direct period", v, 5);
    cur_tag = "R4";
    run(20);

    // R8 strobe counts over two full periods
    cur_tag = "R8";
    zc = 0; pc = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (zero_evt) zc++;
      if (prd_evt) pc++;
    end
    chk(zc == 2, "R8 zero strobes", zc, 2);
    chk(pc == 2, "R8 period strobes", pc, 2);

    // R3 ratio 4*6 = 24
    cur_tag = "R3";
    wr(5'd0, 16'h0988);
    prev = int'(count); hit = 0;
    for (int i = 0; i < 100 && !hit; i++) begin
      @(negedge clk); if (int'(count) != prev) hit = 1;
    end
    prev = int'(count); n = 0; hit = 0;
    for (int i = 0; i < 100 && !hit; i++) begin
      @(negedge clk); n++; if (int'(count) != prev) hit = 1;
    end
    chk(n == 24, "R3 cycles per step", n, 24);
    run(150);

    // R2 register map
    cur_tag = "R2";
    wr(5'd0, 16'hFFFF);
    rd(5'd0, v); chk(v == 16'h1F8B, "R2 masked ctl", v, 16'h1F8B);
    wr(5'd4, 16'h1234);
    rd(5'd0, v);  chk(v == 16'h1F8B, "R2 stray write ctl", v, 16'h1F8B);
    rd(5'd10, v); chk(v == 16'd5, "R2 stray write prd", v, 5);
    rd(5'd4, v);  chk(v == 16'h0, "R2 unmapped read", v, 0);
    run(10);

    // R5 down mode
    cur_tag = "R5";
    wr(5'd0, 16'h0009);
    run(20);

    // R6 up-down
    cur_tag = "R6";
    wr(5'd0, 16'h000A);
    hit = 0;
    for (int i = 0; i < 40 && !hit; i++) begin
      @(negedge clk); if (count == 16'd5 && dir_up) hit = 1;
    end
    @(negedge clk);
    chk(count == 16'd4 && !dir_up, "R6 turn at period", {dir_up, count}, 16'd4);
    run(30);

    // R7 freeze, shadow mode
    cur_tag = "R7";
    wr(5'd0, 16'h0003);
    prev = int'(count); zc = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (zero_evt || prd_evt || int'(count) != prev) zc++;
    end
    chk(zc == 0, "R7 frozen", zc, 0);

    // R9 shadow load
    cur_tag = "R9";
    wr(5'd10, 16'd9);
    rd(5'd10, v); chk(v == 16'd5, "R9 active held", v, 5);
    wr(5'd0, 16'h0000);
    run(30);
    rd(5'd10, v); chk(v == 16'd9, "R9 promoted at zero", v, 9);

    // R11 full period in down mode
    cur_tag = "R11";
    wr(5'd0, 16'h0009);
    wr(5'd10, 16'hFFFF);
    hit = 0;
    for (int i = 0; i < 30 && !hit; i++) begin
      @(negedge clk); if (count == 16'd0) hit = 1;
    end
    @(negedge clk);
    chk(count == 16'hFFFF, "R11 reload max", int'(count), 16'hFFFF);
    run(10);

    summary();
    $finish;
  end
endmodule